// File: doc/BRIEF.md
# Masked-Write Mask Value Encoder

This controller-side block prepares a 64-byte write packet for a value-coded masked write. In that kind of write, the receiving memory stores only the bytes that differ from an 8-bit mask value carried with the command. The controller must therefore pick a value that no byte to be written holds, and it must place that value in every position that is not to be written. This block does both. It takes the packet and a per-byte enable vector. It records which 8-bit values appear among the enabled bytes and picks the lowest value that does not appear. It then returns a copy of the packet in which every disabled byte holds that value, together with the value itself.

A suitable value always exists, because 64 bytes can hold at most 64 of the 256 possible values. When every byte is enabled no masking is needed, so the block flags a plain write and reports a mask value of zero. The search runs over several cycles and walks the packet in lane groups. The caller pulses `start` while the block is idle, waits for the one-cycle `done` pulse, and reads the results, which stay valid until the next `done`.

Top module: `mwr_mask_encoder`

## Requirements
- R1: After reset, `busy`, `done` and `plain_wr` are 0, `mask_val` is 0 and `data_out` is all zeros.
- R2: A `start` seen while idle is accepted. From the next cycle `busy` is 1 until the cycle in which `done` is 1, and in that cycle `busy` is 0.
- R3: `done` is 1 for exactly one cycle. It rises NBYTES/LANES+1 cycles after the clock edge that accepted `start` (5 cycles with the default parameters).
- R4: A `start` given while `busy` is 1 is ignored. It produces no extra `done`, and the results are those of the packet that was accepted.
- R5: When `plain_wr` is 0, `mask_val` differs from every byte of `data_out` whose enable bit is 1.
- R6: `mask_val` is the numerically lowest 8-bit value that no enabled byte holds. With no bytes enabled, it is 0.
- R7: In `data_out`, byte i (bits 8i+7..8i) equals the input byte i when `byte_en[i]` is 1, and equals `mask_val` when `byte_en[i]` is 0.
- R8: When all 64 enable bits are 1, `plain_wr` is 1, `mask_val` is 0 and `data_out` equals the input packet.
- R9: The value held in a disabled byte never counts as used, so it does not stop that value from being chosen.
- R10: `mask_val`, `plain_wr` and `data_out` change only in a cycle in which `done` is 1. Otherwise they hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a search on the presented packet (accepted only while idle) |
| data_in | input | 512 | Packet, byte i at bits 8i+7..8i |
| byte_en | input | 64 | Per-byte write enable, bit i for byte i |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle result-valid pulse |
| plain_wr | output | 1 | All bytes enabled: issue an unmasked write |
| mask_val | output | 8 | Chosen mask value |
| data_out | output | 512 | Packet with disabled bytes replaced by the mask value |

## Verification
On every cycle, the assertions check the control behaviour: `busy` and `done` are never 1 together, `done` lasts one cycle, and `busy` only falls when `done` rises. They also check that the latched packet is frozen during a search and that the outputs hold between results. On each `done` they check that no enabled output byte equals the mask value and that a plain write carries a zero mask. Only the bench scenarios can show that the chosen value is the lowest free one, that disabled bytes are replaced correctly, that disabled-byte contents are ignored, and that the latency is exact. It does this by comparing against values it computes for itself.

// File: rtl/mwe_pkg.sv
// Shared types for the masked-write mask value encoder.
package mwe_pkg;

    localparam int BYTE_W = 8;
    localparam int NVALS  = 1 << BYTE_W;

    // Sequencer phases: wait for work, walk lane groups, publish result.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_PICK = 2'd2
    } mwe_state_e;

endpackage

// File: rtl/mwe_used_map.sv
// Accumulates a map of byte values seen among enabled lanes.
// Assumes: clear and upd are never asserted in the same cycle;
// one group of LANES bytes is folded in per upd cycle.
module mwe_used_map
    import mwe_pkg::*;
#(
    parameter int LANES = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clear,
    input  logic                      upd,
    input  logic [LANES*BYTE_W-1:0]   lane_data,
    input  logic [LANES-1:0]          lane_en,
    output logic [NVALS-1:0]          used
);

    logic [NVALS-1:0] set_vec;

    // Decode each enabled lane's byte into a one-hot value bit.
    always_comb begin
        set_vec = '0;
        for (int i = 0; i < LANES; i++) begin
            if (lane_en[i])
                set_vec[lane_data[i*BYTE_W +: BYTE_W]] = 1'b1;
        end
    end

    // Hold the running map; clear starts a new packet.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            used <= '0;
        else if (upd)
            used <= used | set_vec;
    end

    // R6: a fresh search begins from an empty map.
    p_map_cleared_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (used == '0));

endmodule

// File: rtl/mwe_free_pick.sv
// Finds the lowest-numbered value whose bit is clear in the used map.
// Assumes: purely combinational; found is 0 only if every value is used.
module mwe_free_pick
    import mwe_pkg::*;
(
    input  logic [NVALS-1:0]   used,
    output logic [BYTE_W-1:0]  free_val,
    output logic               found
);

    // Scan from the top down so the lowest clear bit wins last.
    always_comb begin
        free_val = '0;
        found    = 1'b0;
        for (int v = NVALS - 1; v >= 0; v--) begin
            if (!used[v]) begin
                free_val = BYTE_W'(v);
                found    = 1'b1;
            end
        end
    end

endmodule

// File: rtl/mwe_substitute.sv
// Replaces every disabled byte of a packet with the mask value.
// Assumes: combinational; enabled bytes pass through unchanged.
module mwe_substitute
    import mwe_pkg::*;
#(
    parameter int NBYTES = 64
) (
    input  logic [NBYTES*BYTE_W-1:0] pkt,
    input  logic [NBYTES-1:0]        en,
    input  logic [BYTE_W-1:0]        fill,
    output logic [NBYTES*BYTE_W-1:0] pkt_out
);

    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        // Per-lane select between original byte and fill value.
        assign pkt_out[g*BYTE_W +: BYTE_W] = en[g] ? pkt[g*BYTE_W +: BYTE_W] : fill;
    end

endmodule

// File: rtl/mwr_mask_encoder.sv
// Top of the masked-write mask value encoder. Latches a packet and its
// byte enables on an idle start, and folds LANES bytes per cycle into a
// used-value map. It then publishes the lowest unused value, the
// substituted packet and a plain-write flag with a one-cycle done.
// Assumes: NBYTES is a multiple of LANES; byte i sits at bits 8i+7..8i.
module mwr_mask_encoder
    import mwe_pkg::*;
#(
    parameter int NBYTES = 64,
    parameter int LANES  = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [NBYTES*8-1:0]       data_in,
    input  logic [NBYTES-1:0]         byte_en,
    output logic                      busy,
    output logic                      done,
    output logic                      plain_wr,
    output logic [7:0]                mask_val,
    output logic [NBYTES*8-1:0]       data_out
);

    localparam int PKT_BITS  = NBYTES * BYTE_W;
    localparam int LANE_BITS = LANES * BYTE_W;
    localparam int NSTEPS    = NBYTES / LANES;
    localparam int IDX_W     = (NSTEPS > 1) ? $clog2(NSTEPS) : 1;

    mwe_state_e           state;
    logic [IDX_W-1:0]     idx;
    logic [PKT_BITS-1:0]  pkt_q;
    logic [NBYTES-1:0]    en_q;
    logic                 accept;
    logic [NVALS-1:0]     used;
    logic [BYTE_W-1:0]    free_val;
    logic                 free_ok;
    logic [PKT_BITS-1:0]  sub_pkt;
    logic                 all_en;

    assign accept = (state == ST_IDLE) && start;
    assign all_en = &en_q;

    // Walk the packet one lane group per cycle after accept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            idx   <= '0;
        end else begin
            case (state)
                ST_IDLE: if (accept) begin
                    state <= ST_SCAN;
                    idx   <= '0;
                end
                ST_SCAN: begin
                    if (idx == IDX_W'(NSTEPS - 1))
                        state <= ST_PICK;
                    idx <= idx + 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Capture the packet and enables only when a start is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pkt_q <= '0;
            en_q  <= '0;
        end else if (accept) begin
            pkt_q <= data_in;
            en_q  <= byte_en;
        end
    end

    mwe_used_map #(.LANES(LANES)) u_map (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (accept),
        .upd       (state == ST_SCAN),
        .lane_data (pkt_q[int'(idx)*LANE_BITS +: LANE_BITS]),
        .lane_en   (en_q[int'(idx)*LANES +: LANES]),
        .used      (used)
    );

    mwe_free_pick u_pick (
        .used     (used),
        .free_val (free_val),
        .found    (free_ok)
    );

    mwe_substitute #(.NBYTES(NBYTES)) u_sub (
        .pkt     (pkt_q),
        .en      (en_q),
        .fill    (free_val),
        .pkt_out (sub_pkt)
    );

    // Busy spans accept to the publish cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            busy <= 1'b0;
        else if (accept)
            busy <= 1'b1;
        else if (state == ST_PICK)
            busy <= 1'b0;
    end

    // Publish results with a one-cycle done; hold them otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done     <= 1'b0;
            plain_wr <= 1'b0;
            mask_val <= '0;
            data_out <= '0;
        end else begin
            done <= (state == ST_PICK);
            if (state == ST_PICK) begin
                plain_wr <= all_en;
                mask_val <= all_en ? '0 : free_val;
                data_out <= all_en ? pkt_q : sub_pkt;
            end
        end
    end

    // Flags of enabled output bytes that collide with the mask value.
    logic [NBYTES-1:0] clash;
    for (genvar g = 0; g < NBYTES; g++) begin : g_clash
        assign clash[g] = en_q[g] && (data_out[g*BYTE_W +: BYTE_W] == mask_val);
    end

    p_busy_done_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));
    p_busy_falls_at_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
    p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_frozen_while_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(pkt_q) && $stable(en_q)));
    p_free_exists_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PICK) |-> free_ok);
    p_mask_unused_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !plain_wr) |-> (clash == '0));
    p_plain_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && plain_wr) |-> ((mask_val == '0) && all_en));
    p_hold_outputs_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(mask_val) && $stable(plain_wr) && $stable(data_out)));

endmodule

// File: tb/sim_mwr_mask_encoder.sv
module sim_mwr_mask_encoder;

    localparam int NB  = 64;
    localparam int LAT = NB / 16 + 1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [NB*8-1:0] data_in = '0;
    logic [NB-1:0]   byte_en = '0;
    logic            busy, done, plain_wr;
    logic [7:0]      mask_val;
    logic [NB*8-1:0] data_out;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    mwr_mask_encoder #(.NBYTES(NB), .LANES(16)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .data_in(data_in),
        .byte_en(byte_en), .busy(busy), .done(done), .plain_wr(plain_wr),
        .mask_val(mask_val), .data_out(data_out)
    );

    task automatic chk(input bit ok, input string tag, input logic [NB*8-1:0] act,
                       input logic [NB*8-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Independent model: lowest value unused by enabled bytes, substitution.
    task automatic model(input logic [NB*8-1:0] pkt, input logic [NB-1:0] en,
                         output logic [7:0] m, output logic pl,
                         output logic [NB*8-1:0] q);
        bit seen [256];
        for (int v = 0; v < 256; v++) seen[v] = 0;
        for (int i = 0; i < NB; i++) if (en[i]) seen[pkt[i*8 +: 8]] = 1;
        pl = &en;
        m  = 8'd0;
        if (!pl) begin
            for (int v = 255; v >= 0; v--) if (!seen[v]) m = 8'(v);
        end
        for (int i = 0; i < NB; i++) q[i*8 +: 8] = en[i] ? pkt[i*8 +: 8] : m;
    endtask

    // Run one packet; check handshake, latency and results against model.
    task automatic run_pkt(input logic [NB*8-1:0] pkt, input logic [NB-1:0] en,
                           input string tag, input bit poke_busy);
        logic [7:0] em; logic ep; logic [NB*8-1:0] eq;
        int cyc;
        model(pkt, en, em, ep, eq);
        @(negedge clk);
        data_in = pkt; byte_en = en; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        chk(busy === 1'b1, {"R2 busy after start ", tag}, NB*8'(busy), 1);
        if (poke_busy) begin
            @(negedge clk); cyc++;
            data_in = ~pkt; byte_en = ~en; start = 1'b1;
            @(negedge clk); cyc++;
            start = 1'b0;
        end
        while (!done && cyc < 40) begin
            @(negedge clk); cyc++;
        end
        chk(cyc == LAT + 1, {"R3 latency ", tag}, NB*8'(cyc), NB*8'(LAT + 1));
        chk(busy === 1'b0, {"R2 busy low at done ", tag}, NB*8'(busy), 0);
        chk(mask_val === em, {"R6 mask value ", tag}, NB*8'(mask_val), NB*8'(em));
        chk(plain_wr === ep, {"R8 plain flag ", tag}, NB*8'(plain_wr), NB*8'(ep));
        chk(data_out === eq, {"R7 data out ", tag}, data_out, eq);
        @(negedge clk);
        chk(done === 1'b0, {"R3 done single cycle ", tag}, NB*8'(done), 0);
        repeat (3) @(negedge clk);
        chk(done === 1'b0, {"R4 no extra done ", tag}, NB*8'(done), 0);
        chk(mask_val === em && data_out === eq, {"R10 outputs held ", tag},
            data_out, eq);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk(!busy && !done && !plain_wr, "R1 reset flags", NB*8'({busy, done, plain_wr}), 0);
        chk(mask_val === 8'd0 && data_out === '0, "R1 reset data", data_out, '0);
        rst_n = 1'b1;
    endtask

    task automatic t_even_enabled();
        logic [NB*8-1:0] p; logic [NB-1:0] e;
        for (int i = 0; i < NB; i++) begin p[i*8 +: 8] = 8'(i); e[i] = (i % 2 == 0); end
        run_pkt(p, e, "even lanes R5 R7", 0);
    endtask

    task automatic t_all_enabled();
        logic [NB*8-1:0] p;
        for (int i = 0; i < NB; i++) p[i*8 +: 8] = 8'(i * 3 + 1);
        run_pkt(p, '1, "all enabled R8", 0);
    endtask

    task automatic t_none_enabled();
        logic [NB*8-1:0] p;
        for (int i = 0; i < NB; i++) p[i*8 +: 8] = 8'(i + 17);
        run_pkt(p, '0, "none enabled R6", 0);
    endtask

    task automatic t_disabled_ignored();
        logic [NB*8-1:0] p; logic [NB-1:0] e;
        for (int i = 0; i < NB; i++) begin p[i*8 +: 8] = (i == 63) ? 8'd63 : 8'(i); e[i] = (i != 63); end
        run_pkt(p, e, "disabled value 63 chosen R9", 0);
        for (int i = 0; i < NB; i++) begin p[i*8 +: 8] = (i < 8) ? 8'd0 : 8'(i + 100); e[i] = (i >= 8); end
        run_pkt(p, e, "disabled zeros R9", 0);
    endtask

    task automatic t_start_while_busy();
        logic [NB*8-1:0] p; logic [NB-1:0] e;
        for (int i = 0; i < NB; i++) begin p[i*8 +: 8] = 8'(255 - i); e[i] = (i % 3 != 0); end
        p[5*8 +: 8] = 8'd0; p[7*8 +: 8] = 8'd1;
        run_pkt(p, e, "start while busy R4", 1);
    endtask

    initial begin
        t_reset();
        t_even_enabled();
        t_all_enabled();
        t_none_enabled();
        t_disabled_ignored();
        t_start_while_busy();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule